// File: doc/BRIEF.md
# Power-up I/O Option Loader

This block runs once after every reset. It reads a short table of option bytes from a reserved 256-byte region at the top of program memory, starting at `FF00h`. It decodes those bytes into per-pin output-type and pull-up settings for ports 0, 1, 3 and 7, and it holds the CPU off until the table is loaded and a start-up window has run out. The pad configuration of a board is therefore set by the contents of program memory and not at manufacture.

The memory side is a plain synchronous byte read port. The block drives an address and a one-cycle read strobe. The memory returns the byte on the following clock edge. Only one read is ever outstanding. The start-up window is counted in clock cycles by the parameter `WINDOW`. At the default clock it is sized to about 3 ms. Once `run_en` rises, the CPU may begin fetching from address 0000h. The option outputs are registered and stay frozen until the next reset.

Top module: `opt_boot_loader`

## Requirements
- R1: While `rst` is high, and on the edge that samples it, every output-type bit reads 1 (open drain), every pull-up bit reads 0, `mem_rd` is 0 and `run_en` is 0.
- R2: Counting clock edges from the first one with `rst` low, the k-th read strobe (k = 0..5) is high for exactly one cycle, after edge 3k+1. It carries address `FF00h + k`. No further read follows until the next reset.
- R3: Output type, where 1 means open drain and 0 means CMOS. Byte 0 bit i sets port 0 pin i. Byte 2 bit i sets port 1 pin i. Byte 4 bits 3:0 set port 3 pins 3:0.
- R4: The port 0 pull-up option is per nibble. Byte 1 bit 0 covers pins 3:0 and byte 1 bit 1 covers pins 7:4.
- R5: The other pull-up options are per bit. Byte 3 bit i sets port 1 pin i. Byte 4 bit 4+i sets port 3 pin i. Byte 5 bit i sets port 7 pin i, for i = 0..3. A value of 1 means enabled.
- R6: A pin whose output type is open drain reports its pull-up as 0, whatever its pull-up option bit holds.
- R7: Port 7 pins 4 and 5 always report their pull-up as 0. Byte 5 bits 7:4 have no effect.
- R8: A returned byte appears on the option outputs on the second clock edge after the edge at which the memory sampled its strobe.
- R9: `run_en` rises on the edge after both conditions hold: the last byte has been captured, and `WINDOW` edges have passed since reset released. It then stays high until reset.
- R10: Once loading is complete, changes on `mem_data` have no effect on any output and no read is issued.
- R11: A reset during loading abandons it. The fetch restarts from offset 0 when reset releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W | Program memory byte address |
| mem_rd | output | 1 | Read strobe, one cycle per byte |
| mem_data | input | 8 | Byte returned one edge after the strobe is sampled |
| p0_od | output | 8 | Port 0 output type, 1 = open drain |
| p0_pu | output | 8 | Port 0 effective pull-up enable |
| p1_od | output | 8 | Port 1 output type |
| p1_pu | output | 8 | Port 1 effective pull-up enable |
| p3_od | output | 4 | Port 3 output type |
| p3_pu | output | 4 | Port 3 effective pull-up enable |
| p7_pu | output | 6 | Port 7 input pull-up enable |
| run_en | output | 1 | CPU may start at address 0000h |

## Verification
The properties assume the memory answers every strobe on the very next edge with a settled byte, and that `rst` is driven high from time zero. The bench memory answers every strobe one edge later and drives random bytes only after loading has finished. Reset is asserted synchronously at negative edges, including once in the middle of a load. Two instances with a long and a short window cover both orders in which the two conditions for `run_en` can be met.

// File: rtl/opt_boot_pkg.sv
package opt_boot_pkg;

  localparam int OPT_NBYTES = 6;

  // option table byte offsets from the region base
  localparam int OFS_P0_OD = 0;
  localparam int OFS_P0_PU = 1;
  localparam int OFS_P1_OD = 2;
  localparam int OFS_P1_PU = 3;
  localparam int OFS_P3    = 4;
  localparam int OFS_P7_PU = 5;

  typedef enum logic [1:0] {
    FS_REQ,
    FS_WAIT,
    FS_CAP,
    FS_DONE
  } fetch_state_e;

  // safe value of each table byte: open drain everywhere, no pull-ups
  function automatic logic [7:0] byte_default(input int idx);
    case (idx)
      OFS_P0_OD, OFS_P1_OD: return 8'hFF;
      OFS_P3:               return 8'h0F;
      default:              return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/opt_fetch_seq.sv
module opt_fetch_seq
  import opt_boot_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int unsigned OPT_BASE = 32'hFF00,
  parameter int          NBYTES   = OPT_NBYTES,
  parameter int          IDX_W    = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              cap_en,
  output logic [IDX_W-1:0]  cap_idx,
  output logic              done
);

  fetch_state_e st;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= FS_REQ;
      idx      <= '0;
      mem_rd   <= 1'b0;
      mem_addr <= ADDR_W'(OPT_BASE);
      done     <= 1'b0;
    end else begin
      mem_rd <= 1'b0;
      case (st)
        FS_REQ: begin
          mem_rd   <= 1'b1;
          mem_addr <= ADDR_W'(OPT_BASE) + ADDR_W'(idx);
          st       <= FS_WAIT;
        end
        FS_WAIT: st <= FS_CAP;
        FS_CAP: begin
          if (idx == IDX_W'(NBYTES - 1)) begin
            st   <= FS_DONE;
            done <= 1'b1;
          end else begin
            idx <= idx + IDX_W'(1);
            st  <= FS_REQ;
          end
        end
        default: st <= FS_DONE;
      endcase
    end
  end

  assign cap_en  = (st == FS_CAP);
  assign cap_idx = idx;

endmodule

// File: rtl/opt_window_timer.sv
module opt_window_timer #(
  parameter int unsigned WINDOW = 18000,
  parameter int          CNT_W  = $clog2(WINDOW + 1)
) (
  input  logic clk,
  input  logic rst,
  output logic expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (cnt != CNT_W'(WINDOW))
      cnt <= cnt + CNT_W'(1);
  end

  assign expired = (cnt == CNT_W'(WINDOW));

endmodule

// File: rtl/opt_byte_store.sv
module opt_byte_store
  import opt_boot_pkg::*;
#(
  parameter int NBYTES = OPT_NBYTES,
  parameter int IDX_W  = $clog2(NBYTES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cap_en,
  input  logic [IDX_W-1:0]       cap_idx,
  input  logic [7:0]             cap_data,
  output logic [NBYTES-1:0][7:0] raw
);

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= byte_default(g);
      else if (cap_en && cap_idx == IDX_W'(g))
        q <= cap_data;
    end
    assign raw[g] = q;
  end

endmodule

// File: rtl/opt_decode.sv
module opt_decode
  import opt_boot_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic [OPT_NBYTES-1:0][7:0] raw,
  output logic [7:0]                 p0_od,
  output logic [7:0]                 p0_pu,
  output logic [7:0]                 p1_od,
  output logic [7:0]                 p1_pu,
  output logic [3:0]                 p3_od,
  output logic [3:0]                 p3_pu,
  output logic [5:0]                 p7_pu
);

  logic [7:0] p0_pu_n, p1_pu_n;
  logic [3:0] p3_pu_n;
  logic [5:0] p7_pu_n;
  logic       unused_bits;

  // port 0: nibble-wide pull-up option, blocked on open-drain pins
  for (genvar g = 0; g < 8; g++) begin : g_p0
    assign p0_pu_n[g] = raw[OFS_P0_PU][g/4] & ~raw[OFS_P0_OD][g];
  end

  for (genvar g = 0; g < 8; g++) begin : g_p1
    assign p1_pu_n[g] = raw[OFS_P1_PU][g] & ~raw[OFS_P1_OD][g];
  end

  for (genvar g = 0; g < 4; g++) begin : g_p3
    assign p3_pu_n[g] = raw[OFS_P3][4+g] & ~raw[OFS_P3][g];
  end

  for (genvar g = 0; g < 6; g++) begin : g_p7
    if (g < 4) begin : g_opt
      assign p7_pu_n[g] = raw[OFS_P7_PU][g];
    end else begin : g_none
      assign p7_pu_n[g] = 1'b0;
    end
  end

  assign unused_bits = ^{raw[OFS_P0_PU][7:2], raw[OFS_P7_PU][7:4]};

  always_ff @(posedge clk) begin
    if (rst) begin
      p0_od <= '1;
      p1_od <= '1;
      p3_od <= '1;
      p0_pu <= '0;
      p1_pu <= '0;
      p3_pu <= '0;
      p7_pu <= '0;
    end else begin
      p0_od <= raw[OFS_P0_OD];
      p1_od <= raw[OFS_P1_OD];
      p3_od <= raw[OFS_P3][3:0];
      p0_pu <= p0_pu_n;
      p1_pu <= p1_pu_n;
      p3_pu <= p3_pu_n;
      p7_pu <= p7_pu_n;
    end
  end

endmodule

// File: rtl/opt_boot_loader.sv
module opt_boot_loader
  import opt_boot_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int unsigned OPT_BASE = 32'hFF00,
  parameter int unsigned WINDOW   = 18000
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [7:0]        mem_data,
  output logic [7:0]        p0_od,
  output logic [7:0]        p0_pu,
  output logic [7:0]        p1_od,
  output logic [7:0]        p1_pu,
  output logic [3:0]        p3_od,
  output logic [3:0]        p3_pu,
  output logic [5:0]        p7_pu,
  output logic              run_en
);

  localparam int IDX_W = $clog2(OPT_NBYTES);

  logic                       cap_en;
  logic [IDX_W-1:0]           cap_idx;
  logic                       done;
  logic                       expired;
  logic [OPT_NBYTES-1:0][7:0] raw;

  opt_fetch_seq #(
    .ADDR_W(ADDR_W), .OPT_BASE(OPT_BASE), .NBYTES(OPT_NBYTES), .IDX_W(IDX_W)
  ) u_fetch (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .cap_en(cap_en), .cap_idx(cap_idx), .done(done)
  );

  opt_window_timer #(.WINDOW(WINDOW)) u_timer (
    .clk(clk), .rst(rst), .expired(expired)
  );

  opt_byte_store #(.NBYTES(OPT_NBYTES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .cap_en(cap_en), .cap_idx(cap_idx),
    .cap_data(mem_data), .raw(raw)
  );

  opt_decode u_dec (
    .clk(clk), .rst(rst), .raw(raw),
    .p0_od(p0_od), .p0_pu(p0_pu), .p1_od(p1_od), .p1_pu(p1_pu),
    .p3_od(p3_od), .p3_pu(p3_pu), .p7_pu(p7_pu)
  );

  always_ff @(posedge clk) begin
    if (rst)
      run_en <= 1'b0;
    else if (done && expired)
      run_en <= 1'b1;
  end

endmodule

// File: rtl/opt_boot_loader_chk.sv
module opt_boot_loader_chk #(
  parameter int          ADDR_W   = 16,
  parameter int unsigned OPT_BASE = 32'hFF00,
  parameter int unsigned WINDOW   = 18000
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic [7:0]        p0_od,
  input logic [7:0]        p0_pu,
  input logic [7:0]        p1_od,
  input logic [7:0]        p1_pu,
  input logic [3:0]        p3_od,
  input logic [3:0]        p3_pu,
  input logic [5:0]        p7_pu,
  input logic              run_en
);

  int unsigned since_rst;

  always_ff @(posedge clk) begin
    if (rst)
      since_rst <= 0;
    else if (since_rst < WINDOW)
      since_rst <= since_rst + 1;
  end

  a_r1_reset_defaults: assert property (@(posedge clk)
    rst |=> (!run_en && !mem_rd && p0_od == 8'hFF && p1_od == 8'hFF && p3_od == 4'hF
             && p0_pu == 8'h00 && p1_pu == 8'h00 && p3_pu == 4'h0 && p7_pu == 6'h00));

  a_r2_one_cycle_strobe: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  a_r2_addr_in_table: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (32'(mem_addr) >= OPT_BASE && 32'(mem_addr) < OPT_BASE + 6));

  a_r6_od_blocks_pu: assert property (@(posedge clk) disable iff (rst)
    ((p0_pu & p0_od) == 8'h00 && (p1_pu & p1_od) == 8'h00 && (p3_pu & p3_od) == 4'h0));

  a_r7_p7_upper_off: assert property (@(posedge clk) disable iff (rst)
    p7_pu[5:4] == 2'b00);

  a_r9_window_elapsed: assert property (@(posedge clk) disable iff (rst)
    $rose(run_en) |-> since_rst >= WINDOW);

  a_r9_run_sticky: assert property (@(posedge clk) disable iff (rst)
    run_en |=> run_en);

  a_r10_no_read_after_run: assert property (@(posedge clk) disable iff (rst)
    run_en |-> !mem_rd);

  a_r10_options_frozen: assert property (@(posedge clk) disable iff (rst)
    run_en |=> ($stable(p0_od) && $stable(p0_pu) && $stable(p1_od) && $stable(p1_pu)
                && $stable(p3_od) && $stable(p3_pu) && $stable(p7_pu)));

endmodule

bind opt_boot_loader opt_boot_loader_chk #(
  .ADDR_W(ADDR_W), .OPT_BASE(OPT_BASE), .WINDOW(WINDOW)
) u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
  .p0_od(p0_od), .p0_pu(p0_pu), .p1_od(p1_od), .p1_pu(p1_pu),
  .p3_od(p3_od), .p3_pu(p3_pu), .p7_pu(p7_pu), .run_en(run_en)
);

// File: tb/sim_opt_boot_loader.sv
module opt_ref_model #(
  parameter int W = 40
) (
  input logic        clk,
  input logic        rst,
  input logic        mem_rd,
  input logic [15:0] mem_addr,
  input logic [7:0]  mem_data,
  input logic [7:0]  p0_od,
  input logic [7:0]  p0_pu,
  input logic [7:0]  p1_od,
  input logic [7:0]  p1_pu,
  input logic [3:0]  p3_od,
  input logic [3:0]  p3_pu,
  input logic [5:0]  p7_pu,
  input logic        run_en
);
  int checks = 0;
  int fails  = 0;
  int cyc, rd_cnt, cap_cnt;
  bit pend, started;
  logic [7:0] raw [0:5];
  logic [7:0] e_p0od, e_p0pu, e_p1od, e_p1pu;
  logic [3:0] e_p3od, e_p3pu;
  logic [5:0] e_p7pu;
  logic       e_run;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s W=%0d act=%0h exp=%0h t=%0t", tag, W, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      // R1 defaults, R11 restart
      raw[0] = 8'hFF; raw[1] = 8'h00; raw[2] = 8'hFF;
      raw[3] = 8'h00; raw[4] = 8'h0F; raw[5] = 8'h00;
      e_p0od = 8'hFF; e_p1od = 8'hFF; e_p3od = 4'hF;
      e_p0pu = 0; e_p1pu = 0; e_p3pu = 0; e_p7pu = 0; e_run = 0;
      cyc = 0; rd_cnt = 0; cap_cnt = 0; pend = 0;
    end else begin
      if (cap_cnt == 6 && cyc >= W) e_run = 1;           // R9
      // R8: outputs follow the table as it stood before this edge
      e_p0od = raw[0];
      e_p0pu = {{4{raw[1][1]}}, {4{raw[1][0]}}} & ~raw[0]; // R4 R6
      e_p1od = raw[2];
      e_p1pu = raw[3] & ~raw[2];                          // R5 R6
      e_p3od = raw[4][3:0];
      e_p3pu = raw[4][7:4] & ~raw[4][3:0];
      e_p7pu = {2'b00, raw[5][3:0]};                      // R7
      if (pend) begin
        raw[cap_cnt] = mem_data;
        cap_cnt++;
        pend = 0;
      end
      if (mem_rd) begin
        chk(rd_cnt < 6, "R10 read after load", rd_cnt, 5);
        chk(cyc == 3 * rd_cnt + 1, "R2 strobe timing", cyc, 3 * rd_cnt + 1);
        chk(mem_addr == 16'hFF00 + 16'(rd_cnt), "R2 R11 address", mem_addr, 16'hFF00 + rd_cnt);
        pend = 1;
        rd_cnt++;
      end else if (rd_cnt < 6 && cyc == 3 * rd_cnt + 1) begin
        chk(0, "R2 missing strobe", 0, 1);
      end
      cyc++;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk(p0_od == e_p0od && p1_od == e_p1od && p3_od == e_p3od, "R3 R1 output type",
          {p0_od, p1_od, 4'h0, p3_od}, {e_p0od, e_p1od, 4'h0, e_p3od});
      chk(p0_pu == e_p0pu, "R4 R6 port0 pull-up", p0_pu, e_p0pu);
      chk(p1_pu == e_p1pu && p3_pu == e_p3pu && p7_pu[3:0] == e_p7pu[3:0], "R5 R6 pull-ups",
          {p1_pu, p3_pu, 2'b0, p7_pu}, {e_p1pu, e_p3pu, 2'b0, e_p7pu});
      chk(p7_pu[5:4] == 2'b00, "R7 port7 pins 4-5", p7_pu[5:4], 0);
      chk(run_en == e_run, "R9 R1 run enable", run_en, e_run);
    end
  end
endmodule

module sim_opt_boot_loader;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic        junk = 1'b0;
  logic [7:0]  rom [0:255];
  logic [15:0] a0, a1;
  logic        rd0, rd1;
  logic [7:0]  md0 = 8'h00, md1 = 8'h00;
  logic [7:0]  o0_p0od, o0_p0pu, o0_p1od, o0_p1pu, o1_p0od, o1_p0pu, o1_p1od, o1_p1pu;
  logic [3:0]  o0_p3od, o0_p3pu, o1_p3od, o1_p3pu;
  logic [5:0]  o0_p7pu, o1_p7pu;
  logic        run0, run1;
  int checks = 0, fails = 0;
  bit wd_fail = 0;

  opt_boot_loader #(.WINDOW(40)) u0 (
    .clk(clk), .rst(rst), .mem_addr(a0), .mem_rd(rd0), .mem_data(md0),
    .p0_od(o0_p0od), .p0_pu(o0_p0pu), .p1_od(o0_p1od), .p1_pu(o0_p1pu),
    .p3_od(o0_p3od), .p3_pu(o0_p3pu), .p7_pu(o0_p7pu), .run_en(run0));

  opt_boot_loader #(.WINDOW(5)) u1 (
    .clk(clk), .rst(rst), .mem_addr(a1), .mem_rd(rd1), .mem_data(md1),
    .p0_od(o1_p0od), .p0_pu(o1_p0pu), .p1_od(o1_p1od), .p1_pu(o1_p1pu),
    .p3_od(o1_p3od), .p3_pu(o1_p3pu), .p7_pu(o1_p7pu), .run_en(run1));

  opt_ref_model #(.W(40)) r0 (
    .clk(clk), .rst(rst), .mem_rd(rd0), .mem_addr(a0), .mem_data(md0),
    .p0_od(o0_p0od), .p0_pu(o0_p0pu), .p1_od(o0_p1od), .p1_pu(o0_p1pu),
    .p3_od(o0_p3od), .p3_pu(o0_p3pu), .p7_pu(o0_p7pu), .run_en(run0));

  opt_ref_model #(.W(5)) r1 (
    .clk(clk), .rst(rst), .mem_rd(rd1), .mem_addr(a1), .mem_data(md1),
    .p0_od(o1_p0od), .p0_pu(o1_p0pu), .p1_od(o1_p1od), .p1_pu(o1_p1pu),
    .p3_od(o1_p3od), .p3_pu(o1_p3pu), .p7_pu(o1_p7pu), .run_en(run1));

  // synchronous read memories; junk mode scrambles the data bus (R10)
  always @(posedge clk) begin
    if (junk) md0 <= 8'($urandom);
    else if (rd0) md0 <= (a0[15:8] == 8'hFF) ? rom[a0[7:0]] : 8'h00;
  end
  always @(posedge clk) begin
    if (junk) md1 <= 8'($urandom);
    else if (rd1) md1 <= (a1[15:8] == 8'hFF) ? rom[a1[7:0]] : 8'h00;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic load_table(input logic [47:0] t);
    for (int i = 0; i < 6; i++) rom[i] = t[8*i +: 8];
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d",
             checks + r0.checks + r1.checks,
             fails + r0.fails + r1.fails + (wd_fail ? 1 : 0));
  endtask

  initial begin
    logic [31:0] snap;
    for (int i = 0; i < 256; i++) rom[i] = 8'hA5;
    // byte5..byte0: mixed types, nibble pull-up on pins 7:4, p7 bits 5:4 set (R7)
    load_table({8'h3F, 8'hA6, 8'hFF, 8'hC3, 8'h02, 8'h5A});
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (60) @(negedge clk);
    chk(run0 && run1, "R9 both running", {run0, run1}, 3);
    snap = {o0_p0od, o0_p0pu, o0_p1pu, o0_p3pu, o0_p7pu[3:0]};
    junk = 1'b1;
    repeat (20) @(negedge clk);
    chk({o0_p0od, o0_p0pu, o0_p1pu, o0_p3pu, o0_p7pu[3:0]} == snap, "R10 frozen after load",
        {o0_p0od, o0_p0pu, o0_p1pu, o0_p3pu, o0_p7pu[3:0]}, snap);
    junk = 1'b0;

    // all ones: every pin open drain, so no pull-up (R6); reset mid-load (R11)
    rst = 1'b1;
    load_table(48'hFFFF_FFFF_FFFF);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (7) @(negedge clk);
    rst = 1'b1;
    load_table(48'h0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    while (!rd0) @(negedge clk);
    chk(a0 == 16'hFF00, "R11 restart at offset 0", a0, 16'hFF00);
    repeat (60) @(negedge clk);
    chk(o0_p0od == 8'h00 && o0_p0pu == 8'h00, "R3 all CMOS no pull-up",
        {o0_p0od, o0_p0pu}, 0);

    // all CMOS with every pull-up option set
    rst = 1'b1;
    load_table({8'hFF, 8'hF0, 8'hFF, 8'h00, 8'h03, 8'h00});
    repeat (2) @(negedge clk);
    chk(o0_p0od == 8'hFF && run0 == 1'b0, "R1 reset state", {o0_p0od, 7'b0, run0}, 16'hFF00);
    rst = 1'b0;
    repeat (60) @(negedge clk);
    chk(o0_p7pu == 6'h0F, "R7 R5 port7 pull-ups", o0_p7pu, 6'h0F);

    // all ones table without interruption: pull-ups all blocked
    rst = 1'b1;
    load_table(48'hFFFF_FFFF_FFFF);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (60) @(negedge clk);
    chk(o0_p1pu == 8'h00 && o0_p0pu == 8'h00, "R6 open drain blocks pull-up",
        {o0_p0pu, o0_p1pu}, 0);

    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog expired t=%0t", $time);
    wd_fail = 1;
    summary();
    $finish;
  end
endmodule